// File: doc/BRIEF.md
# Key-Locked Watchdog Counter with Stretched Reset

This block is a watchdog for a peripheral bus. Software writes a reload value and a reset-pulse length into two registers. It then starts a down-counter by writing two key words in a row to the control register. While the counter runs, it loses one on every reference tick. Reading the control register returns the live count.

A different two-word key stops the counter and reloads it. Software services the watchdog by sending the stop key and then the start key. If the count reaches zero, the counter stops at zero. One cycle later a sticky watchdog flag sets in a status register and a reset output goes high. The reset output stays high for the programmed number of reference ticks.

Three state machines make up the block. The key detector has the states `KEY_IDLE`, `KEY_RUN_ARMED` and `KEY_HALT_ARMED`. The counter has `CNT_STOPPED`, `CNT_RUNNING` and `CNT_EXPIRED`. The pulse stretcher has `PLS_IDLE` and `PLS_ACTIVE`.

Key detector transitions:
- IDLE goes to RUN_ARMED on a control write of 0xFF00.
- IDLE goes to HALT_ARMED on a control write of 0xEE00.
- Either armed state returns to IDLE on the next write to any register. If that write is the matching second key word, it also fires a start or stop event.

Counter transitions:
- STOPPED goes to RUNNING on a start event.
- RUNNING goes to EXPIRED on the tick that reaches zero.
- Any state goes to STOPPED on a stop event.

Stretcher transitions:
- IDLE goes to ACTIVE on an expiry event.
- ACTIVE goes to IDLE on its last tick.

Top module: `wdt_top`

Register index on `bus_addr`:

| Index | Register |
|-------|----------|
| 0 | reload value |
| 1 | control (key writes, live-count reads) |
| 2 | pulse length |
| 3 | status (watchdog flag at bit 3) |

## Requirements
- R1: After reset the counter is stopped, the reload register and the live count both read all ones, the pulse-length register reads 0, the status register reads 0, and `wd_reset` is low. While stopped, reference ticks leave the count unchanged.
- R2: A control write of 0x0000FF00 followed directly by a control write of 0x000000FF starts the counter. While running, the count drops by exactly one on each cycle with `ref_tick` high and holds on cycles without it.
- R3: A control write of 0x0000EE00 followed directly by a control write of 0x000000EE stops the counter in any state and loads the count from the reload register.
- R4: A key pair is discarded if its second write is not the expected word, or if a write to any other register comes between the two words. A discarded pair leaves the counter's state and count unchanged.
- R5: The tick that takes the count to zero ends counting: the count then reads 0 and no further tick changes it. With a reload of 0, the first tick expires the counter.
- R6: One cycle after expiry, bit 3 of the status register reads 1 and `wd_irq` is high, with every other status bit 0. Writing a 1 to bit 3 clears the flag. A status write with bit 3 at 0 leaves it set.
- R7: `wd_reset` rises one cycle after expiry and stays high for exactly L reference ticks, where L is the pulse length and a length of 0 counts as 1. It then falls.
- R8: A start key sent while the counter is already running does not disturb the count.
- R9: A write to the reload register does not change the live count. The new value takes effect at the next stop key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable per reference-clock tick |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| wd_irq | output | 1 | Watchdog flag, same as status bit 3 |
| wd_reset | output | 1 | Stretched watchdog reset pulse |

## Verification
The bench builds the block with an 8-bit counter and a 4-bit pulse length. With these widths the reset value of 255 can be checked directly, and every pulse length from 0 to 15 can be tried. The sweep covers reload values 0 to 6 against all sixteen pulse lengths, and it predicts count, flag and reset output on every cycle by arithmetic. The zero-reload and zero-length corner cases fall inside that grid.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        REG_RELOAD = 2'd0,
        REG_CTRL   = 2'd1,
        REG_PULSE  = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    localparam logic [15:0] KEY_RUN_A  = 16'hFF00;
    localparam logic [15:0] KEY_RUN_B  = 16'h00FF;
    localparam logic [15:0] KEY_HALT_A = 16'hEE00;
    localparam logic [15:0] KEY_HALT_B = 16'h00EE;

    localparam int WD_FLAG_BIT = 3;

    typedef enum logic [1:0] {
        KEY_IDLE,
        KEY_RUN_ARMED,
        KEY_HALT_ARMED
    } key_state_e;

    typedef enum logic [1:0] {
        CNT_STOPPED,
        CNT_RUNNING,
        CNT_EXPIRED
    } cnt_state_e;

    typedef enum logic {
        PLS_IDLE,
        PLS_ACTIVE
    } pls_state_e;

endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_other,
    input  logic [DATA_W-1:0] wdata,
    output logic              start_evt,
    output logic              stop_evt
);

    localparam logic [DATA_W-1:0] RUN_A  = DATA_W'(KEY_RUN_A);
    localparam logic [DATA_W-1:0] RUN_B  = DATA_W'(KEY_RUN_B);
    localparam logic [DATA_W-1:0] HALT_A = DATA_W'(KEY_HALT_A);
    localparam logic [DATA_W-1:0] HALT_B = DATA_W'(KEY_HALT_B);

    key_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_IDLE: begin
                if (wr_ctrl && wdata == RUN_A)
                    state_d = KEY_RUN_ARMED;
                else if (wr_ctrl && wdata == HALT_A)
                    state_d = KEY_HALT_ARMED;
            end
            KEY_RUN_ARMED, KEY_HALT_ARMED: begin
                if (wr_ctrl || wr_other)
                    state_d = KEY_IDLE;
            end
            default: state_d = KEY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= KEY_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        start_evt = (state_q == KEY_RUN_ARMED)  && wr_ctrl && (wdata == RUN_B);
        stop_evt  = (state_q == KEY_HALT_ARMED) && wr_ctrl && (wdata == HALT_B);
    end

endmodule

// File: rtl/wdt_downcnt.sv
module wdt_downcnt
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             expired,
    output logic             expire_evt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             exp_q, exp_d;

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        exp_d   = 1'b0;
        unique case (state_q)
            CNT_STOPPED: begin
                if (start_evt)
                    state_d = CNT_RUNNING;
            end
            CNT_RUNNING: begin
                if (tick) begin
                    if (count_q <= ONE) begin
                        count_d = '0;
                        state_d = CNT_EXPIRED;
                        exp_d   = 1'b1;
                    end else begin
                        count_d = count_q - ONE;
                    end
                end
            end
            CNT_EXPIRED: begin
                count_d = count_q;
            end
            default: state_d = CNT_STOPPED;
        endcase
        if (stop_evt) begin
            state_d = CNT_STOPPED;
            count_d = reload_val;
            exp_d   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_STOPPED;
            count_q <= '1;
            exp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            exp_q   <= exp_d;
        end
    end

    always_comb begin
        count      = count_q;
        running    = (state_q == CNT_RUNNING);
        expired    = (state_q == CNT_EXPIRED);
        expire_evt = exp_q;
    end

endmodule

// File: rtl/wdt_stretch.sv
module wdt_stretch
    import wdt_pkg::*;
#(
    parameter int PLS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             trigger,
    input  logic [PLS_W-1:0] len,
    output logic             pulse_out
);

    localparam logic [PLS_W-1:0] ONE = PLS_W'(1);

    pls_state_e       state_q, state_d;
    logic [PLS_W-1:0] rem_q, rem_d;

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            PLS_IDLE: begin
                if (trigger) begin
                    state_d = PLS_ACTIVE;
                    rem_d   = (len == '0) ? ONE : len;
                end
            end
            PLS_ACTIVE: begin
                if (tick) begin
                    if (rem_q <= ONE) begin
                        state_d = PLS_IDLE;
                        rem_d   = '0;
                    end else begin
                        rem_d = rem_q - ONE;
                    end
                end
            end
            default: state_d = PLS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PLS_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    always_comb begin
        pulse_out = (state_q == PLS_ACTIVE);
    end

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int PLS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_irq,
    output logic              wd_reset
);

    logic [CNT_W-1:0] reload_q;
    logic [PLS_W-1:0] plen_q;
    logic             flag_q;

    logic wr_reload, wr_ctrl, wr_pulse, wr_status, wr_other;
    logic key_start, key_stop;
    logic [CNT_W-1:0] live_count;
    logic cnt_running, cnt_expired, expire_evt;

    always_comb begin
        wr_reload = bus_wr && (bus_addr == REG_RELOAD);
        wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
        wr_pulse  = bus_wr && (bus_addr == REG_PULSE);
        wr_status = bus_wr && (bus_addr == REG_STATUS);
        wr_other  = wr_reload || wr_pulse || wr_status;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '1;
            plen_q   <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (wr_reload)
                reload_q <= bus_wdata[CNT_W-1:0];
            if (wr_pulse)
                plen_q <= bus_wdata[PLS_W-1:0];
            if (expire_evt)
                flag_q <= 1'b1;
            else if (wr_status && bus_wdata[WD_FLAG_BIT])
                flag_q <= 1'b0;
        end
    end

    wdt_keyseq #(.DATA_W(DATA_W)) u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_other  (wr_other),
        .wdata     (bus_wdata),
        .start_evt (key_start),
        .stop_evt  (key_stop)
    );

    wdt_downcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (ref_tick),
        .start_evt  (key_start),
        .stop_evt   (key_stop),
        .reload_val (reload_q),
        .count      (live_count),
        .running    (cnt_running),
        .expired    (cnt_expired),
        .expire_evt (expire_evt)
    );

    wdt_stretch #(.PLS_W(PLS_W)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (ref_tick),
        .trigger   (expire_evt),
        .len       (plen_q),
        .pulse_out (wd_reset)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_RELOAD: bus_rdata = DATA_W'(reload_q);
            REG_CTRL:   bus_rdata = DATA_W'(live_count);
            REG_PULSE:  bus_rdata = DATA_W'(plen_q);
            REG_STATUS: bus_rdata[WD_FLAG_BIT] = flag_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign wd_irq = flag_q;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_tick,
    input logic             running,
    input logic             expired,
    input logic [CNT_W-1:0] count,
    input logic             stop_evt,
    input logic             expire_evt,
    input logic             wd_irq,
    input logic             wd_reset
);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ref_tick && count > CNT_W'(1) && !stop_evt)
        |=> (count == $past(count) - CNT_W'(1)));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !ref_tick && !stop_evt) |=> (count == $past(count)));

    // R3
    stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!running && !expired));

    // R5
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !stop_evt) |=> (expired && count == '0));

    // R6
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_evt |=> wd_irq);

    // R7
    rst_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_reset) |-> $past(expire_evt));

endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_tick   (ref_tick),
    .running    (cnt_running),
    .expired    (cnt_expired),
    .count      (live_count),
    .stop_evt   (key_stop),
    .expire_evt (expire_evt),
    .wd_irq     (wd_irq),
    .wd_reset   (wd_reset)
);

// File: tb/wdt_top_test.sv
module wdt_top_test;

    localparam int CNT_W = 8;
    localparam int PLS_W = 4;
    localparam logic [1:0] A_RELOAD = 2'd0;
    localparam logic [1:0] A_CTRL   = 2'd1;
    localparam logic [1:0] A_PULSE  = 2'd2;
    localparam logic [1:0] A_STATUS = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_tick;
    logic        bus_wr;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        wd_irq;
    logic        wd_reset;

    int n_cmp  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wdt_top #(.DATA_W(32), .CNT_W(CNT_W), .PLS_W(PLS_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wd_irq    (wd_irq),
        .wd_reset  (wd_reset)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        ref_tick = 1'b1;
        repeat (n) @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    endtask

    task automatic arm(input int n, input int l);
        logic [31:0] v;
        wr(A_PULSE, 32'(l));
        wr(A_RELOAD, 32'(n));
        wr(A_CTRL, 32'h0000EE00);
        wr(A_CTRL, 32'h000000EE);
        wr(A_STATUS, 32'h8);
        rd(A_CTRL, v);
        check("R3 stop key loads reload", v, 32'(n));
        wr(A_CTRL, 32'h0000FF00);
        wr(A_CTRL, 32'h000000FF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        rst_n = 1'b0; ref_tick = 1'b0; bus_wr = 1'b0;
        bus_addr = A_CTRL; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_RELOAD, v); check("R1 reload", v, 32'hFF);
        rd(A_CTRL, v);   check("R1 count", v, 32'hFF);
        rd(A_PULSE, v);  check("R1 pulse len", v, 32'h0);
        rd(A_STATUS, v); check("R1 status", v, 32'h0);
        check("R1 wd_reset", 32'(wd_reset), 32'h0);
        ticks(4);
        rd(A_CTRL, v);   check("R1 stopped holds", v, 32'hFF);

        // R4 intervening write aborts start
        wr(A_CTRL, 32'h0000FF00);
        wr(A_PULSE, 32'h3);
        wr(A_CTRL, 32'h000000FF);
        ticks(3);
        rd(A_CTRL, v); check("R4 intervening write", v, 32'hFF);
        // R4 wrong second word aborts start
        wr(A_CTRL, 32'h0000FF00);
        wr(A_CTRL, 32'h00001234);
        wr(A_CTRL, 32'h000000FF);
        ticks(3);
        rd(A_CTRL, v); check("R4 wrong second word", v, 32'hFF);

        // R2 start and count
        arm(100, 2);
        ticks(2);
        rd(A_CTRL, v); check("R2 decrement", v, 32'd98);
        repeat (3) @(negedge clk);
        rd(A_CTRL, v); check("R2 hold without tick", v, 32'd98);
        // R4 aborted stop while running
        wr(A_CTRL, 32'h0000EE00);
        wr(A_CTRL, 32'h000000EF);
        wr(A_CTRL, 32'h000000EE);
        ticks(2);
        rd(A_CTRL, v); check("R4 bad stop pair", v, 32'd96);
        wr(A_CTRL, 32'h0000EE00);
        wr(A_STATUS, 32'h0);
        wr(A_CTRL, 32'h000000EE);
        ticks(1);
        rd(A_CTRL, v); check("R4 stop with intervening write", v, 32'd95);
        // R8 start while running
        wr(A_CTRL, 32'h0000FF00);
        wr(A_CTRL, 32'h000000FF);
        rd(A_CTRL, v); check("R8 restart no effect", v, 32'd95);
        ticks(2);
        rd(A_CTRL, v); check("R8 still counting", v, 32'd93);
        // R9 reload write leaves live count
        wr(A_RELOAD, 32'd40);
        rd(A_CTRL, v); check("R9 live count kept", v, 32'd93);
        ticks(1);
        rd(A_CTRL, v); check("R9 continues", v, 32'd92);
        wr(A_CTRL, 32'h0000EE00);
        wr(A_CTRL, 32'h000000EE);
        rd(A_CTRL, v); check("R9 new reload at stop", v, 32'd40);
        ticks(2);
        rd(A_CTRL, v); check("R3 stopped holds", v, 32'd40);

        // R2 sparse ticks
        arm(5, 3);
        base = 0;
        for (int k = 0; k < 9; k++) begin
            ref_tick = (k % 3 == 0);
            bus_addr = A_CTRL;
            @(negedge clk);
            if (ref_tick) base++;
            check("R2 sparse tick count", bus_rdata, 32'(5 - base));
        end
        ref_tick = 1'b0;

        // R2 R5 R6 R7 sweep
        for (int n = 0; n <= 6; n++) begin
            for (int l = 0; l < 16; l++) begin
                int np, lp;
                np = (n < 1) ? 1 : n;
                lp = (l < 1) ? 1 : l;
                arm(n, l);
                bus_addr = A_CTRL;
                ref_tick = 1'b1;
                for (int i = 1; i <= np + lp + 2; i++) begin
                    @(negedge clk);
                    if (i < n)
                        check("R2 count", bus_rdata, 32'(n - i));
                    else
                        check("R5 count at zero", bus_rdata, 32'h0);
                    check("R7 reset pulse", 32'(wd_reset),
                          32'((i >= np + 1) && (i <= np + lp)));
                    check("R6 irq flag", 32'(wd_irq), 32'(i >= np + 1));
                end
                ref_tick = 1'b0;
            end
        end

        // R6 status bits and clear
        rd(A_STATUS, v); check("R6 status value", v, 32'h8);
        wr(A_STATUS, 32'h0);
        rd(A_STATUS, v); check("R6 write zero keeps", v, 32'h8);
        wr(A_STATUS, 32'hF7);
        rd(A_STATUS, v); check("R6 other bits keep", v, 32'h8);
        wr(A_STATUS, 32'h8);
        rd(A_STATUS, v); check("R6 w1c clears", v, 32'h0);
        check("R6 irq low", 32'(wd_irq), 32'h0);
        ticks(3);
        rd(A_CTRL, v); check("R5 expired stays zero", v, 32'h0);

        summary();
        $finish;
    end

endmodule